// File: doc/BRIEF.md
# Configuration Text Codec

This block turns a compact character stream into a table of fourteen logic slots, and can turn that table back into the same stream. Each slot describes one two-input gate step: a first operand, a gate kind, a second operand and a destination. A slot with content is sent as four characters (first operand, gate, second operand, destination) closed by a `/`. An empty slot is sent as the `/` alone. A frame is the bytes from a start-of-frame byte through an end-of-frame byte.

Bytes arrive one per cycle over a valid/ready handshake. The parser fills a shadow copy of the table as the bytes arrive. At the end of the frame it copies the shadow into the visible table only if the whole frame was well formed. When the frame ends it reports a format-error flag and an unprogrammed flag, and it pulses a done strobe for one cycle. The optional serializer, selected by a parameter, reads the visible table and emits the same text format on a second valid/ready stream. While the serializer runs, the parser input is held off. The parser only checks the text form. It does not check whether the gate program makes logical sense.

Top module: `cfgtext_codec`

## Requirements
- R1: After reset every slot reads as blank: both operand codes and the destination code are 15, the gate code is 0, and the empty bit is 1. `fmt_err` and `frame_done` are 0, and `unprog` and `in_ready` are 1.
- R2: Operand characters map to 4-bit codes. `0`..`9` give 0..9, `A`..`D` give 10..13, and a space gives 15. This applies in the first-operand, second-operand and destination positions (body characters 1, 3 and 4).
- R3: Gate characters, which are only legal in body position 2, map to 3-bit codes. Space is 0, `&` is 1 (AND), `|` is 2 (OR), `~` is 3 (NOT), `^` is 4 (XOR), `?` is 5 (NAND), `_` is 6 (buffer) and `=` is 7 (XNOR).
- R4: A slot body of four characters followed by `/` yields a slot with empty bit 0 and the decoded fields. A lone `/` yields a blank slot as defined in R1. Slot k of the frame lands at index k; its bits are `[4k+3:4k]` of the operand and destination buses, `[3k+2:3k]` of `tbl_gate`, and bit k of `tbl_empty`.
- R5: When a frame ends, the visible table, `fmt_err` and `unprog` change only in the cycle after the end-of-frame byte is accepted. In that same cycle `frame_done` is 1 for exactly one cycle.
- R6: A frame whose number of `/` terminators is not exactly 14 sets `fmt_err`. The visible table and `unprog` keep their previous values.
- R7: A slot body of a length other than 0 or 4, a character not legal in its position, or characters after the last `/` set `fmt_err`. The previous table is kept.
- R8: A committed frame sets `unprog` to 1 if all 14 slots were empty and to 0 otherwise.
- R9: A byte with `in_sof` set restarts parsing and discards a partial frame. Bytes accepted outside a frame, and cycles with `in_valid` low, have no effect.
- R10: A pulse on `ser_start` makes the serializer emit the visible table in the same format. `out_sof` is set on the first byte and `out_last` on the last byte. The stream holds while `out_ready` is low, and `in_ready` is 0 while the serializer is busy.
- R11: A `ser_start` pulse while the serializer is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can accept a byte |
| in_data | input | 8 | Input character |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| frame_done | output | 1 | One-cycle strobe after a frame ends |
| fmt_err | output | 1 | Last frame was malformed |
| unprog | output | 1 | Visible table has no filled slot |
| tbl_op1 | output | SLOTS*4 | First operand code per slot |
| tbl_gate | output | SLOTS*3 | Gate code per slot |
| tbl_op2 | output | SLOTS*4 | Second operand code per slot |
| tbl_dst | output | SLOTS*4 | Destination code per slot |
| tbl_empty | output | SLOTS | Slot-empty bit per slot |
| ser_start | input | 1 | Start serializing the table |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output character |
| out_sof | output | 1 | Output byte is the first of the frame |
| out_last | output | 1 | Output byte is the last of the frame |

## Verification
The checker assumes that the only way into the visible table is a frame end. Under that assumption, any table movement without `frame_done` is a fault. It also assumes that the consumer may drop `out_ready` in any cycle, and that the output stream must then freeze. The stimulus raises `in_sof` and `in_eof` only on cycles where `in_valid` is high. It never offers frame bytes while a serialization is in flight, so every accepted byte belongs to a frame the bench has modelled. Malformed frames are built by corrupting a well-formed frame in a known way, so the expected error and the kept table are known before sending.

// File: rtl/cfgtext_pkg.sv
package cfgtext_pkg;

  localparam int OPW = 4;
  localparam int GTW = 3;

  localparam logic [OPW-1:0] OP_NONE = 4'hF;
  localparam logic [GTW-1:0] GT_NONE = 3'd0;
  localparam logic [7:0]     CH_TERM = 8'h2F;

  typedef struct packed {
    logic           empty;
    logic [OPW-1:0] op1;
    logic [GTW-1:0] gate;
    logic [OPW-1:0] op2;
    logic [OPW-1:0] dst;
  } slot_t;

  localparam slot_t SLOT_BLANK = '{empty: 1'b1, op1: OP_NONE, gate: GT_NONE,
                                   op2: OP_NONE, dst: OP_NONE};

  // {legal, code}
  function automatic logic [OPW:0] op_decode(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39)      return {1'b1, OPW'(c - 8'h30)};
    else if (c >= 8'h41 && c <= 8'h44) return {1'b1, OPW'(c - 8'h41 + 8'd10)};
    else if (c == 8'h20)               return {1'b1, OP_NONE};
    else                               return '0;
  endfunction

  function automatic logic [GTW:0] gate_decode(input logic [7:0] c);
    case (c)
      8'h20:   return {1'b1, 3'd0};
      8'h26:   return {1'b1, 3'd1};
      8'h7C:   return {1'b1, 3'd2};
      8'h7E:   return {1'b1, 3'd3};
      8'h5E:   return {1'b1, 3'd4};
      8'h3F:   return {1'b1, 3'd5};
      8'h5F:   return {1'b1, 3'd6};
      8'h3D:   return {1'b1, 3'd7};
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] op_encode(input logic [OPW-1:0] code);
    if (code < 4'd10)      return {4'h0, code} + 8'h30;
    else if (code < 4'd14) return {4'h0, code} + 8'h37;
    else                   return 8'h20;
  endfunction

  function automatic logic [7:0] gate_encode(input logic [GTW-1:0] code);
    case (code)
      3'd1:    return 8'h26;
      3'd2:    return 8'h7C;
      3'd3:    return 8'h7E;
      3'd4:    return 8'h5E;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h5F;
      3'd7:    return 8'h3D;
      default: return 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/cfgtext_char_dec.sv
module cfgtext_char_dec
  import cfgtext_pkg::*;
(
  input  logic [7:0]     ch,
  input  logic [2:0]     pos,
  output logic           is_term,
  output logic           legal,
  output logic [OPW-1:0] op_code,
  output logic [GTW-1:0] gt_code
);
  logic [OPW:0] op_r;
  logic [GTW:0] gt_r;

  always_comb begin
    op_r    = op_decode(ch);
    gt_r    = gate_decode(ch);
    is_term = (ch == CH_TERM);
    op_code = op_r[OPW-1:0];
    gt_code = gt_r[GTW-1:0];
    legal   = (pos == 3'd1) ? gt_r[GTW] : op_r[OPW];
  end
endmodule

// File: rtl/cfgtext_slot_store.sv
module cfgtext_slot_store
  import cfgtext_pkg::*;
#(
  parameter int SLOTS = 14,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  slot_t         wr_slot,
  input  logic          commit,
  output slot_t         tbl [SLOTS]
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    slot_t shadow_q;
    slot_t shadow_d;
    logic  hit;

    always_comb begin
      hit      = wr_en && (wr_idx == IW'(i));
      shadow_d = hit ? wr_slot : shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= SLOT_BLANK;
      end else if (hit) begin
        shadow_q <= shadow_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[i] <= SLOT_BLANK;
      end else if (commit) begin
        tbl[i] <= shadow_d;
      end
    end
  end
endmodule

// File: rtl/cfgtext_serializer.sv
module cfgtext_serializer
  import cfgtext_pkg::*;
#(
  parameter int SLOTS = 14,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  slot_t      tbl [SLOTS],
  input  logic       out_ready,
  output logic       busy,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_last
);
  logic          busy_q, busy_d;
  logic [IW-1:0] slot_q, slot_d;
  logic [2:0]    pos_q, pos_d;
  slot_t         cur;
  logic          tail;
  logic          adv;

  always_comb begin
    cur  = tbl[slot_q];
    tail = cur.empty || (pos_q == 3'd4);
    if (cur.empty) begin
      out_data = CH_TERM;
    end else begin
      case (pos_q)
        3'd0:    out_data = op_encode(cur.op1);
        3'd1:    out_data = gate_encode(cur.gate);
        3'd2:    out_data = op_encode(cur.op2);
        3'd3:    out_data = op_encode(cur.dst);
        default: out_data = CH_TERM;
      endcase
    end
    busy     = busy_q;
    out_sof  = busy_q && (slot_q == '0) && (pos_q == 3'd0);
    out_last = busy_q && tail && (slot_q == IW'(SLOTS - 1));
    adv      = busy_q && out_ready;

    busy_d = busy_q;
    slot_d = slot_q;
    pos_d  = pos_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        slot_d = '0;
        pos_d  = 3'd0;
      end
    end else if (adv) begin
      if (tail) begin
        pos_d = 3'd0;
        if (slot_q == IW'(SLOTS - 1)) busy_d = 1'b0;
        else                          slot_d = slot_q + 1'b1;
      end else begin
        pos_d = pos_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      pos_q  <= 3'd0;
    end else if (adv || (start && !busy_q)) begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      pos_q  <= pos_d;
    end
  end
endmodule

// File: rtl/cfgtext_codec.sv
module cfgtext_codec
  import cfgtext_pkg::*;
#(
  parameter int SLOTS  = 14,
  parameter bit EN_SER = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  output logic               frame_done,
  output logic               fmt_err,
  output logic               unprog,
  output logic [SLOTS*4-1:0] tbl_op1,
  output logic [SLOTS*3-1:0] tbl_gate,
  output logic [SLOTS*4-1:0] tbl_op2,
  output logic [SLOTS*4-1:0] tbl_dst,
  output logic [SLOTS-1:0]   tbl_empty,
  input  logic               ser_start,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_sof,
  output logic               out_last
);
  localparam int CW = $clog2(SLOTS + 2);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // parser state
  logic           frame_q, frame_d;
  logic [CW-1:0]  cnt_q, cnt_d, c0;
  logic [2:0]     len_q, len_d, l0;
  logic           err_q, err_d, e0;
  logic           fill_q, fill_d, h0;
  logic [OPW-1:0] f_op1_q, f_op1_d, f_op2_q, f_op2_d, f_dst_q, f_dst_d;
  logic [GTW-1:0] f_gt_q, f_gt_d;
  logic           done_q, fmt_q, unprog_q;

  logic           acc, active, finish, bad, commit;
  logic           len_ok, over;
  logic           is_term, legal;
  logic [OPW-1:0] op_code;
  logic [GTW-1:0] gt_code;
  logic           wr_en;
  slot_t          wr_slot;
  slot_t          tbl [SLOTS];
  logic           ser_busy;

  cfgtext_char_dec u_dec (
    .ch      (in_data),
    .pos     (l0),
    .is_term (is_term),
    .legal   (legal),
    .op_code (op_code),
    .gt_code (gt_code)
  );

  always_comb begin
    acc    = in_valid & in_ready;
    active = acc & (in_sof | frame_q);
    c0     = in_sof ? '0    : cnt_q;
    l0     = in_sof ? 3'd0  : len_q;
    e0     = in_sof ? 1'b0  : err_q;
    h0     = in_sof ? 1'b0  : fill_q;

    cnt_d   = c0;
    len_d   = l0;
    err_d   = e0;
    fill_d  = h0;
    f_op1_d = f_op1_q;
    f_gt_d  = f_gt_q;
    f_op2_d = f_op2_q;
    f_dst_d = f_dst_q;
    wr_en   = 1'b0;
    wr_slot = SLOT_BLANK;
    len_ok  = 1'b0;
    over    = 1'b0;

    if (is_term) begin
      len_ok = (l0 == 3'd0) || (l0 == 3'd4);
      over   = (c0 >= CW'(SLOTS));
      err_d  = e0 | ~len_ok | over;
      wr_en  = active & len_ok & ~over;
      if (l0 != 3'd0) begin
        wr_slot = '{empty: 1'b0, op1: f_op1_q, gate: f_gt_q, op2: f_op2_q, dst: f_dst_q};
      end
      cnt_d  = (c0 == CW'(SLOTS + 1)) ? c0 : c0 + 1'b1;
      len_d  = 3'd0;
      fill_d = h0 | (l0 == 3'd4);
    end else begin
      err_d = e0 | (l0 >= 3'd4) | ~legal;
      case (l0)
        3'd0:    f_op1_d = op_code;
        3'd1:    f_gt_d  = gt_code;
        3'd2:    f_op2_d = op_code;
        3'd3:    f_dst_d = op_code;
        default: ;
      endcase
      len_d = (l0 == 3'd5) ? l0 : l0 + 3'd1;
    end

    frame_d = ~in_eof;
    finish  = active & in_eof;
    bad     = err_d | (cnt_d != CW'(SLOTS)) | (len_d != 3'd0);
    commit  = finish & ~bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      cnt_q   <= '0;
      len_q   <= 3'd0;
      err_q   <= 1'b0;
      fill_q  <= 1'b0;
      f_op1_q <= OP_NONE;
      f_gt_q  <= GT_NONE;
      f_op2_q <= OP_NONE;
      f_dst_q <= OP_NONE;
    end else if (active) begin
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      err_q   <= err_d;
      fill_q  <= fill_d;
      f_op1_q <= f_op1_d;
      f_gt_q  <= f_gt_d;
      f_op2_q <= f_op2_d;
      f_dst_q <= f_dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      fmt_q    <= 1'b0;
      unprog_q <= 1'b1;
    end else begin
      done_q <= finish;
      if (finish) begin
        fmt_q <= bad;
        if (commit) unprog_q <= ~fill_d;
      end
    end
  end

  cfgtext_slot_store #(.SLOTS(SLOTS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (IW'(c0)),
    .wr_slot (wr_slot),
    .commit  (commit),
    .tbl     (tbl)
  );

  if (EN_SER) begin : g_ser
    cfgtext_serializer #(.SLOTS(SLOTS)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ser_start),
      .tbl       (tbl),
      .out_ready (out_ready),
      .busy      (ser_busy),
      .out_data  (out_data),
      .out_sof   (out_sof),
      .out_last  (out_last)
    );
  end else begin : g_noser
    assign ser_busy = 1'b0;
    assign out_data = 8'h00;
    assign out_sof  = 1'b0;
    assign out_last = 1'b0;
  end

  assign out_valid  = ser_busy;
  assign in_ready   = ~ser_busy;
  assign frame_done = done_q;
  assign fmt_err    = fmt_q;
  assign unprog     = unprog_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_flat
    assign tbl_op1[i*4 +: 4]  = tbl[i].op1;
    assign tbl_gate[i*3 +: 3] = tbl[i].gate;
    assign tbl_op2[i*4 +: 4]  = tbl[i].op2;
    assign tbl_dst[i*4 +: 4]  = tbl[i].dst;
    assign tbl_empty[i]       = tbl[i].empty;
  end
endmodule

// File: rtl/cfgtext_codec_chk.sv
module cfgtext_codec_chk #(
  parameter int SLOTS = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               frame_done,
  input logic               fmt_err,
  input logic               unprog,
  input logic [SLOTS*4-1:0] tbl_op1,
  input logic [SLOTS*3-1:0] tbl_gate,
  input logic [SLOTS*4-1:0] tbl_op2,
  input logic [SLOTS*4-1:0] tbl_dst,
  input logic [SLOTS-1:0]   tbl_empty,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data,
  input logic               out_sof
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(tbl_op1) && $stable(tbl_gate) && $stable(tbl_op2)
                    && $stable(tbl_dst) && $stable(tbl_empty));

  assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(fmt_err) && $stable(unprog));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && fmt_err |-> $stable(tbl_op1) && $stable(tbl_gate) && $stable(tbl_op2)
                              && $stable(tbl_dst) && $stable(tbl_empty) && $stable(unprog));

  assert_unprog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !fmt_err |-> (unprog == (&tbl_empty)));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  assert_sof_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  for (genvar i = 0; i < SLOTS; i++) begin : g_blank
    assert_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_empty[i] |-> (tbl_op1[i*4 +: 4] == 4'hF) && (tbl_gate[i*3 +: 3] == 3'd0)
                       && (tbl_op2[i*4 +: 4] == 4'hF) && (tbl_dst[i*4 +: 4] == 4'hF));
  end
endmodule

bind cfgtext_codec cfgtext_codec_chk #(.SLOTS(SLOTS)) chk_i (.*);

// File: tb/cfgtext_codec_tb_top.sv
`timescale 1ns/1ps
module cfgtext_codec_tb_top;
  localparam int SLOTS = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, frame_done, fmt_err, unprog;
  logic [SLOTS*4-1:0] tbl_op1, tbl_op2, tbl_dst;
  logic [SLOTS*3-1:0] tbl_gate;
  logic [SLOTS-1:0]   tbl_empty;
  logic ser_start = 1'b0, out_ready = 1'b0;
  logic out_valid, out_sof, out_last;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  cfgtext_codec #(.SLOTS(SLOTS), .EN_SER(1'b1)) dut_i (.*);

  int checks = 0, failures = 0, cycles = 0;
  string OPCH = "0123456789ABCD ";
  string GTCH = " &|~^?_=";

  int m_op1[SLOTS], m_gt[SLOTS], m_op2[SLOTS], m_dst[SLOTS];
  bit m_emp[SLOTS];
  bit m_unprog = 1'b1;
  int p_op1[SLOTS], p_gt[SLOTS], p_op2[SLOTS], p_dst[SLOTS];
  bit p_emp[SLOTS];
  byte unsigned q[$];

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int op_code_of(int idx);
    return (idx == 14) ? 15 : idx;
  endfunction

  task automatic chk_table(string tag);
    logic [63:0] e1, eg, e2, ed, ee;
    e1 = '0; eg = '0; e2 = '0; ed = '0; ee = '0;
    for (int i = 0; i < SLOTS; i++) begin
      e1[i*4 +: 4] = 4'(m_op1[i]);
      eg[i*3 +: 3] = 3'(m_gt[i]);
      e2[i*4 +: 4] = 4'(m_op2[i]);
      ed[i*4 +: 4] = 4'(m_dst[i]);
      ee[i]        = m_emp[i];
    end
    chk({tag, " op1"},   64'(tbl_op1),   e1);
    chk({tag, " gate"},  64'(tbl_gate),  eg);
    chk({tag, " op2"},   64'(tbl_op2),   e2);
    chk({tag, " dst"},   64'(tbl_dst),   ed);
    chk({tag, " empty"}, 64'(tbl_empty), ee);
  endtask

  task automatic set_blank(int i);
    p_emp[i] = 1'b1; p_op1[i] = 15; p_gt[i] = 0; p_op2[i] = 15; p_dst[i] = 15;
  endtask

  task automatic rand_pending();
    for (int i = 0; i < SLOTS; i++) begin
      if ($urandom % 4 == 0) set_blank(i);
      else begin
        p_emp[i] = 1'b0;
        p_op1[i] = op_code_of($urandom % 15);
        p_gt[i]  = $urandom % 8;
        p_op2[i] = op_code_of($urandom % 15);
        p_dst[i] = op_code_of($urandom % 15);
      end
    end
  endtask

  function automatic byte unsigned opch(int code);
    return OPCH[(code > 14) ? 14 : code];
  endfunction

  task automatic build();
    q.delete();
    for (int i = 0; i < SLOTS; i++) begin
      if (!p_emp[i]) begin
        q.push_back(opch(p_op1[i]));
        q.push_back(GTCH[p_gt[i]]);
        q.push_back(opch(p_op2[i]));
        q.push_back(opch(p_dst[i]));
      end
      q.push_back(8'h2F);
    end
  endtask

  task automatic accept_pending();
    m_unprog = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      m_op1[i] = p_op1[i]; m_gt[i] = p_gt[i]; m_op2[i] = p_op2[i];
      m_dst[i] = p_dst[i]; m_emp[i] = p_emp[i];
      if (!p_emp[i]) m_unprog = 1'b0;
    end
  endtask

  // Send q as one frame; bench never sends while the serializer is busy.
  task automatic send(bit gaps, bit with_eof);
    for (int k = 0; k < q.size(); k++) begin
      if (gaps) begin
        int idle = $urandom % 3;
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
          in_data = 8'($urandom);
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = q[k];
      in_sof   = (k == 0);
      in_eof   = with_eof && (k == q.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_good(string tag, bit gaps);
    build();
    send(gaps, 1'b1);
    accept_pending();
    chk({tag, " R5 done"}, 64'(frame_done), 64'd1);
    chk({tag, " R5 fmt_err"}, 64'(fmt_err), 64'd0);
    chk({tag, " R8 unprog"}, 64'(unprog), 64'(m_unprog));
    chk_table({tag, " R4"});
  endtask

  task automatic send_bad(string tag, int kind);
    rand_pending();
    if (kind >= 5) begin
      p_emp[0] = 1'b0; p_op1[0] = 10; p_gt[0] = 1; p_op2[0] = 11; p_dst[0] = 0;
    end
    build();
    case (kind)
      0: void'(q.pop_back());          // 13 slots: R6
      1: q.push_back(8'h2F);           // 15 slots: R6
      2: q.insert(0, 8'h41);           // body length 1 or 5: R7
      3: q[0] = 8'h23;                 // unknown character: R7
      4: q.push_back(8'h41);           // trailing character: R7
      5: q[1] = 8'h41;                 // operand char in gate position: R7
      default: q.delete(0);            // body length 3: R7
    endcase
    send(1'b1, 1'b1);
    chk({tag, " R6/R7 done"}, 64'(frame_done), 64'd1);
    chk({tag, " R6/R7 fmt_err"}, 64'(fmt_err), 64'd1);
    chk({tag, " R6 unprog kept"}, 64'(unprog), 64'(m_unprog));
    chk_table({tag, " R7 table kept"});
  endtask

  task automatic ser_run(string tag, bit restart);
    byte unsigned got[$];
    int ready_bad = 0, sof_bad = 0, last_pos = -1;
    for (int i = 0; i < SLOTS; i++) begin
      p_op1[i] = m_op1[i]; p_gt[i] = m_gt[i]; p_op2[i] = m_op2[i];
      p_dst[i] = m_dst[i]; p_emp[i] = m_emp[i];
    end
    build();
    @(negedge clk);
    ser_start = 1'b1;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      ser_start = restart && (cyc == 3);  // R11: ignored while busy
      out_ready = ($urandom % 4) != 0;
      if (out_valid && in_ready) ready_bad++;
      if (out_valid && out_ready) begin
        if (out_sof != (got.size() == 0)) sof_bad++;
        got.push_back(out_data);
        if (out_last) begin
          last_pos = got.size();
          break;
        end
      end
    end
    @(negedge clk);
    ser_start = 1'b0;
    out_ready = 1'b0;
    chk({tag, " R10 length"}, 64'(got.size()), 64'(q.size()));
    for (int k = 0; k < q.size() && k < got.size(); k++)
      chk({tag, " R10 byte"}, 64'(got[k]), 64'(q[k]));
    chk({tag, " R10 last on final byte"}, 64'(last_pos), 64'(q.size()));
    chk({tag, " R10 sof only first"}, 64'(sof_bad), 64'd0);
    chk({tag, " R10 in_ready low while busy"}, 64'(ready_bad), 64'd0);
    chk({tag, " R11 idle after end"}, 64'(out_valid), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0c0d));
    for (int i = 0; i < SLOTS; i++) begin
      m_op1[i] = 15; m_gt[i] = 0; m_op2[i] = 15; m_dst[i] = 15; m_emp[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fmt_err", 64'(fmt_err), 64'd0);
    chk("R1 frame_done", 64'(frame_done), 64'd0);
    chk("R1 unprog", 64'(unprog), 64'd1);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk_table("R1 reset table");

    ser_run("R10 blank table", 1'b0);

    // R8: fourteen slashes only
    for (int i = 0; i < SLOTS; i++) set_blank(i);
    send_good("R8 all empty", 1'b0);
    @(negedge clk);
    chk("R5 done is one cycle", 64'(frame_done), 64'd0);

    // R2/R3: every operand and gate character
    for (int i = 0; i < SLOTS; i++) begin
      p_emp[i] = 1'b0;
      p_op1[i] = i;
      p_gt[i]  = i % 8;
      p_op2[i] = (i + 1) % 14;
      p_dst[i] = (i == 12) ? 15 : (i + 5) % 14;
    end
    p_op1[13] = 15; p_gt[13] = 0; p_op2[13] = 15; p_dst[13] = 15;  // four spaces
    send_good("R2 R3 every char", 1'b0);
    ser_run("R10 full table", 1'b1);

    // R6/R7 malformed frames
    for (int kind = 0; kind < 7; kind++) send_bad($sformatf("bad kind %0d", kind), kind);

    // R9: stray bytes outside a frame
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_eof = (k % 3 == 2);
        in_data = (k % 2) ? 8'h2F : 8'h41;
        if (frame_done) seen++;
      end
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0;
      if (frame_done) seen++;
      @(negedge clk);
      chk("R9 stray bytes no done", 64'(seen), 64'd0);
      chk_table("R9 stray bytes table kept");
    end

    // R9: partial frame then restart with a fresh start-of-frame
    q.delete();
    q.push_back(8'h41); q.push_back(8'h26); q.push_back(8'h42); q.push_back(8'h2F);
    q.push_back(8'h31);
    send(1'b0, 1'b0);
    chk("R9 partial no done", 64'(frame_done), 64'd0);
    rand_pending();
    send_good("R9 restart", 1'b1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom % 3 != 0) begin
        rand_pending();
        send_good($sformatf("rand good %0d", n), 1'b1);
      end else begin
        send_bad($sformatf("rand bad %0d", n), $urandom % 7);
      end
      if (n % 8 == 7) ser_run($sformatf("R10 R11 rand %0d", n), 1'b1);
    end

    summary();
    $finish;
  end
endmodule